// File: doc/BRIEF.md
# Distinguished Point Collection Buffer

This block gathers result records from several parallel random-walk engines and hands them to a single host link. An engine asserts its request when its current point meets the distinguished property. It then presents a record made of the point's x-coordinate and the two coefficients that tie the point to the base points. The buffer grants one engine per cycle in rotating order, stores the record in a small FIFO and answers with a one-cycle acknowledge. An engine that is refused keeps its request high, so no record is lost.

To drain the buffer the host raises a lock request. The buffer answers with a lock grant. While the grant is held, no engine may deposit a record. The host pulls each record as three words over a valid/ready stream, always coordinate first, then c, then d. The grant falls on its own once the last stored record has left. It also falls when the host withdraws its request. The number of stored records and a full flag are exported.

Top module: `dp_collect_buf`

## Requirements
- R1: A captured record is transmitted as three beats with tx_sel values 0 (x-coordinate), 1 (c coefficient) and 2 (d coefficient), in that order, and tx_last is high only on the d beat.
- R2: When several engines request in the same cycle, the acknowledge goes to the first requester found after the most recently acknowledged engine, counting upward with wrap-around. After reset, engine 0 ranks first.
- R3: In each cycle a write is possible, exactly one requesting engine receives a combinational acknowledge in the cycle its record is captured. At most one engine is acknowledged per cycle, and never one that is not requesting.
- R4: When the FIFO holds DEPTH records, buf_full is high and no engine is acknowledged. The refused engine's record is captured later, unchanged.
- R5: lock_gnt rises on the clock edge after a cycle in which lock_req is high, the lock is armed, and the FIFO holds, or is being written with, at least one record. It never rises while the FIFO is empty.
- R6: No engine is acknowledged in any cycle in which lock_gnt is high.
- R7: tx_valid is high exactly when lock_gnt is high and the FIFO is not empty. A beat that is not accepted keeps its data and selector in the next cycle.
- R8: After the d beat of the last stored record is accepted, lock_gnt falls on the next edge. It is not granted again until lock_req has been low for at least one cycle.
- R9: If lock_req goes low while granted, lock_gnt falls on the next edge. A partly sent record stays stored and is sent again from its x-coordinate beat on the next lock.
- R10: rec_count equals the number of captured records not yet fully sent, and records leave in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | NUM_CORES | Per-engine deposit request, held until acknowledged |
| core_x | input | NUM_CORES*FIELD_W | Per-engine x-coordinate, engine i at bits i*FIELD_W |
| core_c | input | NUM_CORES*FIELD_W | Per-engine c coefficient |
| core_d | input | NUM_CORES*FIELD_W | Per-engine d coefficient |
| core_ack | output | NUM_CORES | Capture acknowledge, one cycle |
| lock_req | input | 1 | Host request to lock and drain |
| lock_gnt | output | 1 | Lock held by the host |
| rec_count | output | $clog2(DEPTH+1) | Stored record count |
| buf_full | output | 1 | FIFO full |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Host accepts word |
| tx_data | output | FIELD_W | Output word |
| tx_sel | output | 2 | Field of current word: 0 x, 1 c, 2 d |
| tx_last | output | 1 | Last word of a record |

## Verification
Directed bursts with all engines requesting at once separate correct rotating priority from fixed priority. They also fill the FIFO, which shows that refused engines stall rather than lose records. Random per-engine arrivals mixed with random lock requests and random host back-pressure test field order, stall stability and record order against a queue model. The random lock drops land mid-record, which separates restarting a record from its first field from resuming it partway. Holding the lock through an auto-release confirms that the lock does not re-arm until the request has been dropped.

// File: rtl/dp_buf_pkg.sv
package dp_buf_pkg;
    typedef enum logic [1:0] {
        FLD_X = 2'd0,
        FLD_C = 2'd1,
        FLD_D = 2'd2
    } fld_e;
endpackage

// File: rtl/dp_rr_arb.sv
module dp_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic found;
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = int'(st_q.last) + off;
            if (idx >= N) idx = idx - N;
            if (en && !found && req[idx]) begin
                gnt[idx]    = 1'b1;
                found       = 1'b1;
                st_d.last   = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.last <= IDX_W'(N - 1);
        else        st_q      <= st_d;
    end

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/dp_rec_fifo.sv
module dp_rec_fifo #(
    parameter int REC_W = 48,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [REC_W-1:0]             push_data,
    input  logic                         pop,
    output logic [REC_W-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [REC_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= push_data;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !pop);
endmodule

// File: rtl/dp_host_tx.sv
module dp_host_tx
    import dp_buf_pkg::*;
#(
    parameter int FIELD_W = 16,
    parameter int CNT_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_req,
    input  logic                 push,
    input  logic [CNT_W-1:0]     count,
    input  logic [3*FIELD_W-1:0] head,
    input  logic                 tx_ready,
    output logic                 lock_gnt,
    output logic                 pop,
    output logic                 tx_valid,
    output logic [FIELD_W-1:0]   tx_data,
    output logic [1:0]           tx_sel,
    output logic                 tx_last
);
    typedef struct packed {
        logic gnt;
        logic armed;
        fld_e fld;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   beat;

    always_comb begin
        st_d     = st_q;
        tx_valid = st_q.gnt && (count != '0);
        beat     = tx_valid && tx_ready;
        pop      = beat && (st_q.fld == FLD_D);
        if (!lock_req) st_d.armed = 1'b1;
        if (st_q.gnt) begin
            if (!lock_req) begin
                st_d.gnt = 1'b0;
                st_d.fld = FLD_X;
            end else begin
                if (beat) st_d.fld = (st_q.fld == FLD_D) ? FLD_X : fld_e'(st_q.fld + 2'd1);
                if (pop && count == CNT_W'(1)) begin
                    st_d.gnt   = 1'b0;
                    st_d.armed = 1'b0;
                end
            end
        end else if (lock_req && st_q.armed && (count != '0 || push)) begin
            st_d.gnt = 1'b1;
            st_d.fld = FLD_X;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{gnt: 1'b0, armed: 1'b1, fld: FLD_X};
        else        st_q <= st_d;
    end

    assign lock_gnt = st_q.gnt;
    assign tx_data  = head[st_q.fld * FIELD_W +: FIELD_W];
    assign tx_sel   = st_q.fld;
    assign tx_last  = (st_q.fld == FLD_D);

    // R7
    valid_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> lock_gnt);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && lock_req) |=> (tx_valid && $stable(tx_data) && $stable(tx_sel)));
    // R8
    auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == CNT_W'(1)) |=> !lock_gnt);
    // R9
    drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_gnt && !lock_req) |=> !lock_gnt);
endmodule

// File: rtl/dp_collect_buf.sv
module dp_collect_buf #(
    parameter int NUM_CORES = 4,
    parameter int FIELD_W   = 16,
    parameter int DEPTH     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CORES-1:0]           core_req,
    input  logic [NUM_CORES*FIELD_W-1:0]   core_x,
    input  logic [NUM_CORES*FIELD_W-1:0]   core_c,
    input  logic [NUM_CORES*FIELD_W-1:0]   core_d,
    output logic [NUM_CORES-1:0]           core_ack,
    input  logic                           lock_req,
    output logic                           lock_gnt,
    output logic [$clog2(DEPTH+1)-1:0]     rec_count,
    output logic                           buf_full,
    output logic                           tx_valid,
    input  logic                           tx_ready,
    output logic [FIELD_W-1:0]             tx_data,
    output logic [1:0]                     tx_sel,
    output logic                           tx_last
);
    localparam int REC_W = 3 * FIELD_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                 wr_en;
    logic [NUM_CORES-1:0] gnt;
    logic                 push;
    logic [REC_W-1:0]     push_rec;
    logic                 pop;
    logic [REC_W-1:0]     head;

    assign wr_en = !lock_gnt && !buf_full;

    dp_rr_arb #(.N(NUM_CORES)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (core_req),
        .en    (wr_en),
        .gnt   (gnt)
    );

    always_comb begin
        push_rec = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (gnt[i]) push_rec = push_rec | {core_d[i*FIELD_W +: FIELD_W],
                                               core_c[i*FIELD_W +: FIELD_W],
                                               core_x[i*FIELD_W +: FIELD_W]};
        end
    end

    assign push     = |gnt;
    assign core_ack = gnt;

    dp_rec_fifo #(.REC_W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_rec),
        .pop       (pop),
        .head      (head),
        .count     (rec_count),
        .full      (buf_full)
    );

    dp_host_tx #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .push     (push),
        .count    (rec_count),
        .head     (head),
        .tx_ready (tx_ready),
        .lock_gnt (lock_gnt),
        .pop      (pop),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_sel   (tx_sel),
        .tx_last  (tx_last)
    );

    // R6
    no_write_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_gnt |-> (core_ack == '0));
    // R4
    no_ack_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> (core_ack == '0));
    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_ack) |=> (rec_count == $past(rec_count) + 1'b1));
endmodule

// File: tb/dp_collect_buf_bench.sv
module dp_collect_buf_bench;
    localparam int N = 4;
    localparam int W = 16;
    localparam int DEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] core_req = '0;
    logic [N*W-1:0] core_x = '0, core_c = '0, core_d = '0;
    logic [N-1:0] core_ack;
    logic lock_req = 1'b0, lock_gnt, buf_full, tx_valid, tx_ready = 1'b0, tx_last;
    logic [CW-1:0] rec_count;
    logic [W-1:0] tx_data;
    logic [1:0] tx_sel;

    always #4 clk = ~clk;

    dp_collect_buf #(.NUM_CORES(N), .FIELD_W(W), .DEPTH(DEPTH)) u_dp_collect_buf (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_x(core_x), .core_c(core_c),
        .core_d(core_d), .core_ack(core_ack), .lock_req(lock_req), .lock_gnt(lock_gnt),
        .rec_count(rec_count), .buf_full(buf_full), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sel(tx_sel), .tx_last(tx_last)
    );

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [3*W-1:0] model_q[$];
    logic [N-1:0]   pend = '0;
    logic [3*W-1:0] prec [N];
    int  rr_last = N - 1;
    bit  exp_gnt = 0, exp_armed = 1;
    int  exp_fld = 0;
    bit  h_req = 0, h_rdy = 0;
    int  sent = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int rr_pick(input logic [N-1:0] r, input int last);
        for (int off = 1; off <= N; off++) begin
            int i;
            i = (last + off) % N;
            if (r[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [W-1:0] fld_of(input logic [3*W-1:0] r, input int f);
        return r[f*W +: W];
    endfunction

    task automatic load_core(input int k);
        prec[k] = {16'($urandom), 16'($urandom), 16'($urandom)};
        pend[k] = 1'b1;
    endtask

    task automatic step();
        int  win;
        bit  pushed, popped, beat;
        int  sz_before;
        @(negedge clk);
        chk(rec_count == CW'(model_q.size()), "R10 count", rec_count, model_q.size());
        chk(lock_gnt == exp_gnt, "R5 lock_gnt", lock_gnt, exp_gnt);
        chk(buf_full == (model_q.size() == DEPTH), "R4 full", buf_full, model_q.size() == DEPTH);
        core_req = pend;
        for (int k = 0; k < N; k++) begin
            core_x[k*W +: W] = fld_of(prec[k], 0);
            core_c[k*W +: W] = fld_of(prec[k], 1);
            core_d[k*W +: W] = fld_of(prec[k], 2);
        end
        lock_req = h_req;
        tx_ready = h_rdy;
        #1;
        pushed = 0;
        win = -1;
        if (!exp_gnt && model_q.size() < DEPTH) win = rr_pick(pend, rr_last);
        if (win >= 0) begin
            chk(core_ack == N'(1 << win), "R2 rr ack", core_ack, 1 << win);
        end else if (exp_gnt) begin
            chk(core_ack == '0, "R6 ack in lock", core_ack, 0);
        end else begin
            chk(core_ack == '0, "R4 ack when full/idle", core_ack, 0);
        end
        chk(tx_valid == (exp_gnt && model_q.size() > 0), "R7 tx_valid", tx_valid,
            exp_gnt && model_q.size() > 0);
        beat = 0;
        if (tx_valid && model_q.size() > 0) begin
            chk(tx_sel == 2'(exp_fld), "R1 tx_sel", tx_sel, exp_fld);
            chk(tx_data == fld_of(model_q[0], exp_fld), "R1 tx_data", tx_data,
                fld_of(model_q[0], exp_fld));
            chk(tx_last == (exp_fld == 2), "R1 tx_last", tx_last, exp_fld == 2);
            beat = tx_ready;
        end
        sz_before = model_q.size();
        popped = beat && exp_fld == 2;
        if (win >= 0 && core_ack == N'(1 << win)) begin
            model_q.push_back(prec[win]);
            pend[win] = 1'b0;
            rr_last = win;
            pushed = 1;
        end
        if (popped) begin
            void'(model_q.pop_front());
            sent++;
        end
        if (exp_gnt) begin
            if (!h_req) begin
                exp_gnt = 0; exp_fld = 0;
            end else begin
                if (beat) exp_fld = (exp_fld == 2) ? 0 : exp_fld + 1;
                if (popped && sz_before == 1) begin
                    exp_gnt = 0; exp_armed = 0;
                end
            end
        end else if (h_req && exp_armed && (sz_before > 0 || pushed)) begin
            exp_gnt = 1; exp_fld = 0;
        end
        if (!h_req) exp_armed = 1;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_d1a7));
        for (int k = 0; k < N; k++) prec[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk(rec_count == '0, "R10 reset count", rec_count, 0);
        chk(lock_gnt == 1'b0, "R5 reset gnt", lock_gnt, 0);
        chk(tx_valid == 1'b0, "R7 reset valid", tx_valid, 0);
        chk(buf_full == 1'b0, "R4 reset full", buf_full, 0);
        // lock on empty FIFO: no grant (R5)
        h_req = 1;
        repeat (3) step();
        h_req = 0;
        step();
        // all cores at once: rotating order R2, then full stall R4
        for (int k = 0; k < N; k++) load_core(k);
        repeat (N) step();
        load_core(1);
        load_core(2);
        repeat (3) step();
        chk(buf_full == 1'b1, "R4 full after burst", buf_full, 1);
        chk(pend[1] && pend[2], "R4 stalled cores pending", pend, 6);
        // drain with back-pressure, hold lock through auto release (R8)
        h_req = 1;
        for (int i = 0; i < 40; i++) begin
            h_rdy = (i % 3) != 0;
            step();
        end
        chk(lock_gnt == 1'b0, "R8 no regrant while held", lock_gnt, 0);
        h_req = 0; h_rdy = 0;
        repeat (2) step();
        // partial record then drop (R9)
        load_core(0);
        repeat (2) step();
        h_req = 1; h_rdy = 1;
        repeat (3) step();
        h_req = 0;
        step();
        h_req = 1;
        repeat (6) step();
        h_req = 0;
        step();
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < N; k++)
                if (!pend[k] && ($urandom % 8) == 0) load_core(k);
            if (($urandom % 10) == 0) h_req = !h_req;
            h_rdy = ($urandom % 4) != 0;
            step();
        end
        // final drain
        pend = '0;
        h_req = 0;
        step();
        h_req = 1; h_rdy = 1;
        repeat (3 * DEPTH + 6) step();
        chk(model_q.size() == 0 && rec_count == '0, "R10 drained", rec_count, 0);
        chk(sent > 20, "R1 records delivered", sent, 21);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule